// File: doc/BRIEF.md
# E1 Timeslot-0 Overhead Inserter

This block sits in the E1 serial path that leads to the receive-side line output. It takes one data bit per transfer and passes the stream on with one register stage. For each overhead bit in timeslot 0 it decides whether to pass the incoming bit or to write a value of its own. Frame alignment (FAS) frames are the even frames of each eight-frame sub-multiframe. They carry the seven-bit alignment word in bit positions 1 to 7. The odd frames carry the A bit and the spare bits Sa4 to Sa8. The A bit and the spare bits Sa4, Sa5, Sa7 and Sa8 each have their own override select and value. The four Sa6 bits of a sub-multiframe share one select and are filled from a 4-bit value. The alignment word has one group select; when it is set, the correct pattern is written.

Upstream framing logic marks the first bit of every frame with a start-of-frame strobe. It also marks the first frame of a sub-multiframe with a second strobe, given on the same transfer. Software sets the selects and values through a small write port. A write lands in a staging copy. The copy becomes active on the next accepted start-of-frame bit, so every frame is built entirely from one set of settings.

Both stream sides use valid/ready. The output holds its bit and its valid until the bit is taken. The input is ready whenever the output stage is empty or is being emptied in the same cycle. A beat counts only on a cycle with valid and ready both high, and a stall loses or repeats no bit.

Top module: `e1_oh_inserter`

## Requirements
- R1: In reset `out_valid` is 0. After reset `in_ready` is 1, and every override select is clear, so all bits pass unchanged.
- R2: Each accepted input bit appears on `out_data` with `out_valid` in the next cycle. Bits keep their order, and bits outside the overhead positions keep their value.
- R3: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` do not change.
- R4: Register address 0 bits 0..4 select override for the A bit, Sa4, Sa5, Sa7 and Sa8. Address 1 bits 0..4 give their values in the same order. In odd frames these fields land at bit indices 2, 3, 4, 6 and 7, where index 0 is the start-of-frame bit.
- R5: Address 0 bit 5 selects override for Sa6. Address 2 bits 3..0 hold the value, and bit k is written at bit index 5 of odd frame 2k+1.
- R6: Address 0 bit 6 selects override for the alignment word. In even frames, bit indices 1..7 then carry 0,0,1,1,0,1,1 in that order.
- R7: Bit index 0 of every frame, and bit index 1 of odd frames, always pass unchanged.
- R8: A register write becomes active at the next accepted start-of-frame bit. A write made partway through a frame does not change the rest of that frame.
- R9: An accepted start-of-frame bit with the sub-multiframe strobe sets the frame number to 0. Without that strobe the frame number goes up by one, modulo 8.
- R10: Until the first accepted start-of-frame bit after reset, every bit passes unchanged, whatever the registers hold.
- R11: A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Block can take an input bit |
| in_data | input | 1 | Input serial bit |
| in_sof | input | 1 | This bit is bit index 0 of a frame |
| in_smf | input | 1 | With in_sof: frame is frame 0 of a sub-multiframe |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream takes the output bit |
| out_data | output | 1 | Output serial bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |

## Verification
The bench builds the block with `FRAME_BITS` set to 32 instead of 256. This makes each frame short enough that every table vector can run a whole eight-frame sub-multiframe. The bench can therefore reach every Sa6 slot and the parity of every frame. It also covers frame-number wrap, mid-frame register writes and stalls within an affordable run. The timeslot-0 layout does not depend on frame length, so the override positions are the same as at the default length.

// File: rtl/e1_oh_pkg.sv
package e1_oh_pkg;

  localparam int SMF_FRAMES = 8;
  localparam int FRM_W      = $clog2(SMF_FRAMES);
  localparam int TS0_BITS   = 8;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 2;

  // alignment word, MSB goes to bit index 1
  localparam logic [6:0] FAS_WORD = 7'b0011011;

  // override select positions
  localparam int OV_A   = 0;
  localparam int OV_SA4 = 1;
  localparam int OV_SA5 = 2;
  localparam int OV_SA7 = 3;
  localparam int OV_SA8 = 4;
  localparam int OV_SA6 = 5;
  localparam int OV_FAS = 6;
  localparam int OV_W   = 7;
  localparam int VAL_W  = 5;
  localparam int SA6_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_SELECT = 2'd0,
    RA_VALUE  = 2'd1,
    RA_SA6    = 2'd2,
    RA_SPARE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [OV_W-1:0]  ovr;
    logic [VAL_W-1:0] val;
    logic [SA6_W-1:0] sa6;
  } oh_cfg_t;

  // odd-frame bit index -> field: 0..4 single-bit field, 5 Sa6 group, -1 none
  function automatic int odd_field(input int idx);
    case (idx)
      2:       return OV_A;
      3:       return OV_SA4;
      4:       return OV_SA5;
      5:       return OV_SA6;
      6:       return OV_SA7;
      7:       return OV_SA8;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/e1_oh_position.sv
module e1_oh_position
  import e1_oh_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int BIT_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             smf,
  output logic             cur_sync,
  output logic [BIT_W-1:0] cur_bit,
  output logic [FRM_W-1:0] cur_frm,
  output logic             boundary
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic             synced_q;
  logic [BIT_W-1:0] bit_q;
  logic [FRM_W-1:0] frm_q;

  always_comb begin
    boundary = beat && sof;
    cur_sync = synced_q || sof;
    cur_bit  = sof ? '0 : bit_q;
    if (sof) cur_frm = smf ? '0 : frm_q + 1'b1;
    else     cur_frm = frm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      bit_q    <= '0;
      frm_q    <= '0;
    end else if (beat) begin
      synced_q <= cur_sync;
      frm_q    <= cur_frm;
      bit_q    <= (cur_bit == LAST_BIT) ? LAST_BIT : cur_bit + 1'b1;
    end
  end

endmodule

// File: rtl/e1_oh_cfg_regs.sv
module e1_oh_cfg_regs
  import e1_oh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              boundary,
  output oh_cfg_t           cfg_use,
  output oh_cfg_t           cfg_act
);

  oh_cfg_t stage_q;
  oh_cfg_t active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_SELECT: stage_q.ovr <= wr_data[OV_W-1:0];
        RA_VALUE:  stage_q.val <= wr_data[VAL_W-1:0];
        RA_SA6:    stage_q.sa6 <= wr_data[SA6_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        active_q <= '0;
    else if (boundary) active_q <= stage_q;
  end

  // the frame-start bit already belongs to the new frame
  assign cfg_use = boundary ? stage_q : active_q;
  assign cfg_act = active_q;

endmodule

// File: rtl/e1_oh_bit_select.sv
module e1_oh_bit_select
  import e1_oh_pkg::*;
#(
  parameter int BIT_W = 8
) (
  input  logic             din,
  input  logic             cur_sync,
  input  logic [BIT_W-1:0] cur_bit,
  input  logic [FRM_W-1:0] cur_frm,
  input  oh_cfg_t          cfg,
  output logic             dout
);

  logic [TS0_BITS-1:0] even_en, even_val;
  logic [TS0_BITS-1:0] odd_en, odd_val;
  logic [1:0]          sa6_idx;

  assign sa6_idx = cur_frm[2:1];

  for (genvar i = 0; i < TS0_BITS; i++) begin : g_pos
    localparam int FLD = odd_field(i);
    localparam int FI  = (i == 0) ? 0 : 7 - i;

    if (i == 0) begin : g_even_none
      assign even_en[i]  = 1'b0;
      assign even_val[i] = 1'b0;
    end else begin : g_even_fas
      assign even_en[i]  = cfg.ovr[OV_FAS];
      assign even_val[i] = FAS_WORD[FI];
    end

    if (FLD < 0) begin : g_odd_none
      assign odd_en[i]  = 1'b0;
      assign odd_val[i] = 1'b0;
    end else if (FLD == OV_SA6) begin : g_odd_sa6
      assign odd_en[i]  = cfg.ovr[OV_SA6];
      assign odd_val[i] = cfg.sa6[sa6_idx];
    end else begin : g_odd_single
      assign odd_en[i]  = cfg.ovr[FLD];
      assign odd_val[i] = cfg.val[FLD];
    end
  end

  logic       in_ts0;
  logic [2:0] pos;

  always_comb begin
    in_ts0 = cur_sync && (cur_bit < BIT_W'(TS0_BITS));
    pos    = cur_bit[2:0];
    dout   = din;
    if (in_ts0) begin
      if (cur_frm[0]) begin
        if (odd_en[pos]) dout = odd_val[pos];
      end else begin
        if (even_en[pos]) dout = even_val[pos];
      end
    end
  end

endmodule

// File: rtl/e1_oh_inserter.sv
module e1_oh_inserter
  import e1_oh_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int BIT_W      = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_data,
  input  logic              in_sof,
  input  logic              in_smf,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data
);

  logic             beat;
  logic             cur_sync;
  logic [BIT_W-1:0] cur_bit;
  logic [FRM_W-1:0] cur_frm;
  logic             boundary;
  oh_cfg_t          cfg_use;
  oh_cfg_t          cfg_act;
  logic             sel_bit;

  assign in_ready = !out_valid || out_ready;
  assign beat     = in_valid && in_ready;

  e1_oh_position #(.FRAME_BITS(FRAME_BITS), .BIT_W(BIT_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .sof      (in_sof),
    .smf      (in_smf),
    .cur_sync (cur_sync),
    .cur_bit  (cur_bit),
    .cur_frm  (cur_frm),
    .boundary (boundary)
  );

  e1_oh_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .boundary (boundary),
    .cfg_use  (cfg_use),
    .cfg_act  (cfg_act)
  );

  e1_oh_bit_select #(.BIT_W(BIT_W)) u_sel (
    .din      (in_data),
    .cur_sync (cur_sync),
    .cur_bit  (cur_bit),
    .cur_frm  (cur_frm),
    .cfg      (cfg_use),
    .dout     (sel_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sel_bit;
    end
  end

endmodule

// File: rtl/e1_oh_inserter_chk.sv
module e1_oh_inserter_chk
  import e1_oh_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    in_valid,
  input logic    in_ready,
  input logic    in_data,
  input logic    in_sof,
  input logic    out_valid,
  input logic    out_ready,
  input logic    out_data,
  input logic    boundary,
  input oh_cfg_t cfg_act
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid);

  p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_no_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_bit0_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof) |=> (out_data == $past(in_data)));

  p_cfg_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(cfg_act));

endmodule

bind e1_oh_inserter e1_oh_inserter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .boundary  (boundary),
  .cfg_act   (cfg_act)
);

// File: tb/e1_oh_inserter_test.sv
module e1_oh_inserter_test;

  localparam int FB = 32;
  localparam logic [6:0] FAS_EXP = 7'b0011011;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_data = 1'b0, in_sof = 1'b0, in_smf = 1'b0;
  logic       in_ready;
  logic       out_valid, out_data;
  logic       out_ready = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;

  always #2.5 clk = ~clk;

  e1_oh_inserter #(.FRAME_BITS(FB)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_smf(in_smf),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  typedef struct packed {
    logic [6:0] ovr;
    logic [4:0] val;
    logic [3:0] sa6;
    logic [7:0] seed;
    logic       bp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h00, 5'h00, 4'h0, 8'h11, 1'b0},
    '{7'h7F, 5'h1F, 4'hF, 8'h23, 1'b0},
    '{7'h7F, 5'h00, 4'h0, 8'h5A, 1'b1},
    '{7'h15, 5'h0A, 4'hA, 8'h77, 1'b1},
    '{7'h4A, 5'h15, 4'h5, 8'h3C, 1'b0},
    '{7'h20, 5'h00, 4'h6, 8'h91, 1'b1}
  };

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic bp = 1'b0;

  // bench model
  logic [6:0] st_ovr = '0, ac_ovr = '0;
  logic [4:0] st_val = '0, ac_val = '0;
  logic [3:0] st_sa6 = '0, ac_sa6 = '0;
  logic       m_sync = 1'b0;
  int         m_frm = 0, m_bit = 0;
  string      tag_force = "";

  logic  exp_q [$];
  string tag_q [$];

  task automatic check(input logic ok, input string tag, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic dbit(input int seed, input int f, input int b);
    logic [15:0] h;
    h = 16'(seed * 97 + f * 29 + b * 13 + b * b);
    return h[3] ^ h[6];
  endfunction

  function automatic logic model(input logic din, input int f, input int b, output string tag);
    logic e;
    e = din;
    tag = "R2";
    if (!m_sync) tag = "R10";
    else if (b < 8) begin
      if (b == 0) tag = "R7";
      else if (f % 2 == 0) begin
        tag = "R6";
        if (ac_ovr[6]) e = FAS_EXP[7 - b];
      end else begin
        case (b)
          1: tag = "R7";
          2: begin tag = "R4"; if (ac_ovr[0]) e = ac_val[0]; end
          3: begin tag = "R4"; if (ac_ovr[1]) e = ac_val[1]; end
          4: begin tag = "R4"; if (ac_ovr[2]) e = ac_val[2]; end
          5: begin tag = "R5"; if (ac_ovr[5]) e = ac_sa6[f / 2]; end
          6: begin tag = "R4"; if (ac_ovr[3]) e = ac_val[3]; end
          7: begin tag = "R4"; if (ac_ovr[4]) e = ac_val[4]; end
          default: ;
        endcase
      end
    end
    if (tag_force != "") tag = tag_force;
    return e;
  endfunction

  always @(negedge clk) begin
    cyc++;
    out_ready <= !bp || (cyc % 3 != 0);
  end

  // output monitor
  logic stall_prev = 1'b0, stall_data = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (stall_prev && out_valid)
        check(out_data == stall_data, "R3 stall hold", out_data, stall_data);
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R3 ready rule", in_ready, 1'b0);
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R2 extra output", out_data, 1'b0);
        else begin
          logic  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end
    end else stall_prev = 1'b0;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: st_ovr = d[6:0];
      2'd1: st_val = d[4:0];
      2'd2: st_sa6 = d[3:0];
      default: ;
    endcase
  endtask

  task automatic send(input logic d, input logic sof, input logic smf);
    logic  taken;
    string t;
    in_valid = 1'b1; in_data = d; in_sof = sof; in_smf = smf;
    taken = 1'b0;
    while (!taken) begin
      #1;
      taken = in_ready;
      if (taken) begin
        if (sof) begin
          m_sync = 1'b1;
          m_frm  = smf ? 0 : (m_frm + 1) % 8;
          m_bit  = 0;
          ac_ovr = st_ovr; ac_val = st_val; ac_sa6 = st_sa6;
        end
        exp_q.push_back(model(d, m_frm, m_bit, t));
        tag_q.push_back(t);
        m_bit++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_smf = 1'b0;
  endtask

  task automatic send_frame(input logic smf, input int seed, input logic mid, input logic [7:0] mid_ovr);
    int f;
    f = smf ? 0 : (m_frm + 1) % 8;
    for (int b = 0; b < FB; b++) begin
      send(dbit(seed, f, b), b == 0, smf && b == 0);
      if (mid && b == 3) wr(2'd0, mid_ovr);
    end
  endtask

  task automatic drain();
    bp = 1'b0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R2 drain", 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      #1 check(out_valid == 1'b0, "R1 reset valid", out_valid, 1'b0);
    end
    rst_n = 1'b1;
    st_ovr = '0; st_val = '0; st_sa6 = '0;
    ac_ovr = '0; ac_val = '0; ac_sa6 = '0;
    m_sync = 1'b0; m_frm = 0; m_bit = 0;
    @(negedge clk);
    #1 check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();

    // R10: registers set but no frame start seen yet
    wr(2'd0, 8'h7F); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    for (int b = 0; b < 12; b++) send(dbit(5, 0, b), 1'b0, 1'b0);
    drain();

    // R1: defaults after reset are transparent
    do_reset();
    tag_force = "R1";
    send_frame(1'b1, 8'h42, 1'b0, 8'h00);
    send_frame(1'b0, 8'h42, 1'b0, 8'h00);
    tag_force = "";
    drain();

    // table walk: R4, R5, R6, R7, R2, R3
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, {1'b0, VECS[i].ovr});
      wr(2'd1, {3'b0, VECS[i].val});
      wr(2'd2, {4'b0, VECS[i].sa6});
      bp = VECS[i].bp;
      for (int f = 0; f < 8; f++)
        send_frame(f == 0, VECS[i].seed, 1'b0, 8'h00);
      drain();
    end

    // R8: mid-frame write applies from the next frame on
    wr(2'd0, 8'h00); wr(2'd1, 8'h1F); wr(2'd2, 8'h0F);
    tag_force = "R8";
    send_frame(1'b1, 8'h66, 1'b0, 8'h00);
    send_frame(1'b0, 8'h66, 1'b1, 8'h7F);
    send_frame(1'b0, 8'h66, 1'b0, 8'h00);
    send_frame(1'b0, 8'h66, 1'b0, 8'h00);
    tag_force = "";
    drain();

    // R9: frame numbering, resync and wrap (FAS + Sa6 expose parity/slot)
    wr(2'd0, 8'h60); wr(2'd2, 8'h09);
    tag_force = "R9";
    send_frame(1'b1, 8'h2B, 1'b0, 8'h00);
    send_frame(1'b0, 8'h2B, 1'b0, 8'h00);
    send_frame(1'b0, 8'h2B, 1'b0, 8'h00);
    send_frame(1'b1, 8'h2B, 1'b0, 8'h00);
    for (int k = 0; k < 10; k++) send_frame(1'b0, 8'h2B, 1'b0, 8'h00);
    tag_force = "";
    drain();

    // R11: address 3 write leaves everything transparent
    wr(2'd0, 8'h00);
    wr(2'd3, 8'hFF);
    tag_force = "R11";
    send_frame(1'b1, 8'h3E, 1'b0, 8'h00);
    send_frame(1'b0, 8'h3E, 1'b0, 8'h00);
    tag_force = "";
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule